// File: doc/BRIEF.md
# DRAM refresh and initialization engine

This block keeps an asynchronous DRAM array alive and brings it up safely after power is applied. Out of reset it holds the memory pins idle for a programmable power-up pause. It then runs a fixed number of warm-up refresh cycles on its own authority, and only after that does it declare the memory ready for normal traffic.

Once ready, an interval timer adds one refresh to a backlog every row interval. The default setting is 780 cycles, which is about 15.6 us at 50 MHz, so that 4096 rows are covered in 64 ms. While the backlog is non-empty and the engine is idle, it asks the access sequencer for the bus through a request/grant handshake. When the grant comes, the engine takes the bus and drives one refresh cycle.

A static mode input picks one of two refresh kinds:
- **CAS-before-RAS refresh.** The device counts the rows itself, and the write strobe stays high so that the cycle can never be decoded as a test-mode entry.
- **RAS-only refresh.** The engine presents its own wrapping row counter on the address lines.

The backlog saturates at a parameterized limit. At that limit an urgency flag tells the sequencer that the refresh must win the next arbitration.

Top module: `rfsh_engine`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1, ready, req and urgent are 0, and own is 1.
- R2: After reset is released, ras_n does not fall during the first INIT_CYC cycles. The first fall comes no later than INIT_CYC+8 cycles after release.
- R3: After the pause, exactly INIT_REFS refresh cycles run without any grant. ready rises only after the last of them has ended with ras_n high.
- R4: In every refresh, ras_n stays low for exactly RAS_CYC cycles. Between two falls, ras_n stays high for at least PRE_CYC+LEAD_CYC cycles.
- R5: With ras_only_mode=0 (CAS-before-RAS), cas_n is low in the cycle before ras_n falls and stays low while ras_n is low. we_n is 1 at all times.
- R6: With ras_only_mode=1 (RAS-only), cas_n is 1 whenever ras_n is low. row_addr is stable while ras_n is low. row_addr advances by 1 modulo 2^ROW_W from one refresh to the next, wrapping from all-ones to 0.
- R7: After ready, one refresh is added to the backlog every REFI_CYC cycles. When the grant follows req at once, successive ras_n falls are exactly REFI_CYC cycles apart.
- R8: After ready, no refresh starts unless gnt was 1 while req was 1. own is 1 throughout every refresh.
- R9: The backlog saturates at MAX_PEND, and urgent is 1 only when the backlog is full. When the grant returns after a long withholding, MAX_PEND refreshes are performed, plus at most one for a tick that arrives during service.
- R10: Once ready is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | Static mode: 0 = CAS-before-RAS refresh, 1 = RAS-only refresh |
| gnt | input | 1 | Bus grant from the access sequencer |
| req | output | 1 | Refresh backlog non-empty and engine idle (after ready) |
| urgent | output | 1 | Backlog full; the refresh must win arbitration |
| own | output | 1 | Engine drives the DRAM control pins; the sequencer must stay off |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row counter presented on the address lines |
| ready | output | 1 | Initialization complete; normal accesses allowed |

## Verification
The assertions assume the following about the inputs:
- ras_only_mode changes only while reset is held.
- gnt matters only while req is high and own is low, and the sequencer never drives the DRAM pins while own is high.

The bench changes the mode only inside a reset pulse. It raises gnt only from req, either at once, held low for a withholding window, or randomly with a forced grant whenever urgent is set. This keeps every handshake inside those assumptions while still building a full backlog and a row-counter wrap.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_RAS  = 2'd2,
        PH_PRE  = 2'd3
    } rfsh_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_ctl_t;

    function automatic rfsh_phase_e next_phase(rfsh_phase_e ph);
        case (ph)
            PH_LEAD: return PH_RAS;
            PH_RAS:  return PH_PRE;
            default: return PH_IDLE;
        endcase
    endfunction

    // Strobe levels per phase; the write strobe is never lowered.
    function automatic dram_ctl_t phase_pins(rfsh_phase_e ph, logic ras_only);
        dram_ctl_t p;
        p.ras_n = 1'b1;
        p.cas_n = 1'b1;
        p.we_n  = 1'b1;
        case (ph)
            PH_LEAD: p.cas_n = ras_only;
            PH_RAS: begin
                p.ras_n = 1'b0;
                p.cas_n = ras_only;
            end
            default: ;
        endcase
        return p;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
    parameter int unsigned PERIOD = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic full
);
    localparam int unsigned CW = $clog2(MAX_PEND + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_PEND);

    logic [CW-1:0] cnt_q;

    assign full    = (cnt_q == TOP);
    assign nonzero = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (!full)   cnt_q <= cnt_q + 1'b1;
                2'b01:   if (nonzero) cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    p_pend_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        full && inc && !dec |=> full);

    p_empty_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !nonzero && !inc |=> !nonzero);

endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq
    import rfsh_pkg::*;
#(
    parameter int unsigned ROW_W    = 12,
    parameter int unsigned LEAD_CYC = 1,
    parameter int unsigned RAS_CYC  = 4,
    parameter int unsigned PRE_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_mode,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output dram_ctl_t        pins,
    output logic [ROW_W-1:0] row
);
    localparam int unsigned MAXL = max3(LEAD_CYC, RAS_CYC, PRE_CYC);
    localparam int unsigned LW   = (MAXL > 1) ? $clog2(MAXL) : 1;
    localparam int unsigned RW   = $clog2(RAS_CYC + 1) + 1;

    function automatic logic [LW-1:0] phase_len(rfsh_phase_e ph);
        case (ph)
            PH_LEAD: return LW'(LEAD_CYC - 1);
            PH_RAS:  return LW'(RAS_CYC - 1);
            PH_PRE:  return LW'(PRE_CYC - 1);
            default: return '0;
        endcase
    endfunction

    rfsh_phase_e      phase_q;
    logic [LW-1:0]    cnt_q;
    logic [ROW_W-1:0] row_q;

    assign busy = (phase_q != PH_IDLE);
    assign done = (phase_q == PH_PRE) && (cnt_q == '0);
    assign pins = phase_pins(phase_q, ras_only_mode);
    assign row  = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    phase_q <= PH_LEAD;
                    cnt_q   <= phase_len(PH_LEAD);
                end
            end else if (cnt_q == '0) begin
                phase_q <= next_phase(phase_q);
                cnt_q   <= phase_len(next_phase(phase_q));
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (done && ras_only_mode) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    // Checker state: length of the current row-strobe low run.
    logic [RW-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst || pins.ras_n) low_run_q <= '0;
        else                   low_run_q <= low_run_q + 1'b1;
    end

    p_ras_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.ras_n) |-> low_run_q == RW'(RAS_CYC));

    p_cas_lead_r5: assert property (@(posedge clk) disable iff (rst)
        !ras_only_mode && $fell(pins.ras_n) |-> !pins.cas_n && $past(!pins.cas_n));

    p_we_high_r5: assert property (@(posedge clk) disable iff (rst)
        !pins.ras_n |-> pins.we_n);

    p_cas_high_r6: assert property (@(posedge clk) disable iff (rst)
        ras_only_mode && !pins.ras_n |-> pins.cas_n);

    p_row_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !pins.ras_n && !$fell(pins.ras_n) |-> $stable(row_q));

endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine
    import rfsh_pkg::*;
#(
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned INIT_CYC  = 10000,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned REFI_CYC  = 780,
    parameter int unsigned MAX_PEND  = 8,
    parameter int unsigned LEAD_CYC  = 1,
    parameter int unsigned RAS_CYC   = 4,
    parameter int unsigned PRE_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_mode,
    input  logic             gnt,
    output logic             req,
    output logic             urgent,
    output logic             own,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             ready
);
    localparam int unsigned IW = $clog2(INIT_REFS + 1);

    logic      pause_tick, pause_done_q;
    logic      ival_tick;
    logic      pend_nz, pend_full;
    logic      seq_busy, seq_done, seq_start;
    logic      ready_q;
    logic [IW-1:0] init_cnt_q;
    dram_ctl_t pins;

    rfsh_tick_gen #(.PERIOD(INIT_CYC)) u_pause (
        .clk (clk),
        .rst (rst),
        .en  (!pause_done_q),
        .tick(pause_tick)
    );

    rfsh_tick_gen #(.PERIOD(REFI_CYC)) u_ival (
        .clk (clk),
        .rst (rst),
        .en  (ready_q),
        .tick(ival_tick)
    );

    rfsh_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .inc    (ival_tick),
        .dec    (seq_done && ready_q),
        .nonzero(pend_nz),
        .full   (pend_full)
    );

    rfsh_cycle_seq #(
        .ROW_W   (ROW_W),
        .LEAD_CYC(LEAD_CYC),
        .RAS_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ras_only_mode(ras_only_mode),
        .start        (seq_start),
        .busy         (seq_busy),
        .done         (seq_done),
        .pins         (pins),
        .row          (row_addr)
    );

    assign req       = ready_q && pend_nz && !seq_busy;
    assign seq_start = !seq_busy && (ready_q ? (req && gnt) : pause_done_q);
    assign own       = !ready_q || seq_busy;
    assign urgent    = pend_full;
    assign ready     = ready_q;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_done_q <= 1'b0;
            ready_q      <= 1'b0;
            init_cnt_q   <= '0;
        end else begin
            if (pause_tick) pause_done_q <= 1'b1;
            if (seq_done && !ready_q) begin
                init_cnt_q <= init_cnt_q + 1'b1;
                if (init_cnt_q == IW'(INIT_REFS - 1)) ready_q <= 1'b1;
            end
        end
    end

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !pause_done_q |-> ras_n && cas_n);

    p_grant_needed_r8: assert property (@(posedge clk) disable iff (rst)
        ready_q && $past(ready_q) && $rose(seq_busy) |-> $past(req && gnt));

    p_own_active_r8: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> own);

    p_ready_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> ready_q);

    p_urgent_req_r9: assert property (@(posedge clk) disable iff (rst)
        urgent |-> ready_q);

endmodule

// File: tb/sim_rfsh_engine.sv
module sim_rfsh_engine;
    localparam int ROW_W     = 4;
    localparam int INIT_CYC  = 50;
    localparam int INIT_REFS = 8;
    localparam int REFI_CYC  = 40;
    localparam int MAX_PEND  = 3;
    localparam int LEAD_CYC  = 1;
    localparam int RAS_CYC   = 4;
    localparam int PRE_CYC   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_only_mode = 1'b0;
    logic gnt = 1'b0;
    logic req, urgent, own, ras_n, cas_n, we_n, ready;
    logic [ROW_W-1:0] row_addr;

    always #10 clk = ~clk;   // 50 MHz

    rfsh_engine #(
        .ROW_W(ROW_W), .INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS),
        .REFI_CYC(REFI_CYC), .MAX_PEND(MAX_PEND), .LEAD_CYC(LEAD_CYC),
        .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .gnt(gnt),
        .req(req), .urgent(urgent), .own(own), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .row_addr(row_addr), .ready(ready)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int next_row(input int r);
        return (r + 1) % (1 << ROW_W);
    endfunction

    function automatic int min_gap();
        return PRE_CYC + LEAD_CYC;
    endfunction

    // Grant policy: 0 = follow req at once, 1 = withhold, 2 = random with urgency
    int gmode = 0;
    always @(negedge clk) begin
        if (rst) gnt <= 1'b0;
        else case (gmode)
            0:       gnt <= req;
            1:       gnt <= 1'b0;
            default: gnt <= req && (urgent || ($urandom_range(3) == 0));
        endcase
    end

    // Pin monitor
    int  cyc, falls, falls_init, first_fall, low_len, high_len, last_post, prev_addr;
    bit  ras_prev, cas_prev, ready_seen, have_addr, wrap_seen, chk_ival;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; falls = 0; falls_init = 0; first_fall = -1; low_len = 0;
            high_len = 0; last_post = -1; prev_addr = 0; ras_prev = 1'b1;
            cas_prev = 1'b1; ready_seen = 1'b0; have_addr = 1'b0; wrap_seen = 1'b0;
        end else begin
            cyc++;
            if (!chk_ival) last_post = -1;
            if (ready_seen && !ready) check(0, "R10 ready dropped", 0, 1);
            if (ready && !ready_seen) begin
                ready_seen = 1'b1;
                check(ras_n == 1'b1, "R3 ras_n high at ready", int'(ras_n), 1);
            end
            if (ras_prev && !ras_n) begin
                falls++;
                if (!ready_seen) falls_init++;
                if (first_fall < 0) first_fall = cyc;
                if (falls > 1) check(high_len >= min_gap(), "R4 precharge gap", high_len, min_gap());
                if (!ras_only_mode) begin
                    check(cas_prev == 1'b0, "R5 cas_n lead before ras_n fall", int'(cas_prev), 0);
                end else begin
                    if (have_addr) begin
                        check(int'(row_addr) == next_row(prev_addr), "R6 row advance",
                              int'(row_addr), next_row(prev_addr));
                        if (prev_addr == (1 << ROW_W) - 1 && row_addr == '0) wrap_seen = 1'b1;
                    end
                    prev_addr = int'(row_addr);
                    have_addr = 1'b1;
                end
                if (ready_seen) begin
                    if (chk_ival && last_post >= 0)
                        check(cyc - last_post == REFI_CYC, "R7 refresh spacing", cyc - last_post, REFI_CYC);
                    last_post = cyc;
                end
            end
            if (!ras_prev && ras_n) begin
                check(low_len == RAS_CYC, "R4 ras_n low width", low_len, RAS_CYC);
                low_len = 0;
                high_len = 0;
            end
            if (!ras_n) begin
                low_len++;
                if (!own) check(0, "R8 own low during refresh", 0, 1);
                if (!we_n) check(0, "R5 we_n low during refresh", 0, 1);
                if (!ras_only_mode && cas_n) check(0, "R5 cas_n high during ras_n low", 1, 0);
                if (ras_only_mode && !cas_n) check(0, "R6 cas_n low in RAS-only", 0, 1);
                if (ras_only_mode && int'(row_addr) != prev_addr)
                    check(0, "R6 row_addr not stable", int'(row_addr), prev_addr);
            end else begin
                high_len++;
            end
            ras_prev = ras_n;
            cas_prev = cas_n;
        end
    end

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1;
        ras_only_mode = mode;
        gmode = 0;
        repeat (3) @(negedge clk);
        check(ras_n && cas_n && we_n, "R1 strobes idle in reset", int'({ras_n, cas_n, we_n}), 7);
        check(!ready && !req && !urgent, "R1 ready/req/urgent low in reset",
              int'({ready, req, urgent}), 0);
        check(own == 1'b1, "R1 own high in reset", int'(own), 1);
        rst = 1'b0;
    endtask

    task automatic wait_ready(input int lim);
        for (int i = 0; i < lim && !ready; i++) @(negedge clk);
        check(ready == 1'b1, "R3 ready reached", int'(ready), 1);
        check(first_fall >= INIT_CYC, "R2 pause before first refresh", first_fall, INIT_CYC);
        check(first_fall <= INIT_CYC + 8, "R2 first refresh after pause", first_fall, INIT_CYC + 8);
        check(falls_init == INIT_REFS, "R3 warm-up refresh count", falls_init, INIT_REFS);
    endtask

    int base, delta, seed_dummy;

    initial begin
        chk_ival = 1'b0;
        seed_dummy = $urandom(32'd4711);

        // CAS-before-RAS mode
        do_reset(1'b0);
        wait_ready(2000);
        chk_ival = 1'b1;
        repeat (5 * REFI_CYC + 5) @(negedge clk);
        check(falls - falls_init >= 4, "R7 periodic refreshes issued", falls - falls_init, 4);

        // Withhold the grant: backlog fills, urgency rises
        chk_ival = 1'b0;
        gmode = 1;
        repeat (10) @(negedge clk);
        base = falls;
        for (int i = 0; i < 4 * REFI_CYC && !req; i++) @(negedge clk);
        check(req == 1'b1, "R7 req raised by interval", int'(req), 1);
        check(urgent == 1'b0, "R9 urgent low before backlog full", int'(urgent), 0);
        repeat ((MAX_PEND + 1) * REFI_CYC) @(negedge clk);
        check(falls == base, "R8 no refresh without grant", falls - base, 0);
        check(urgent == 1'b1, "R9 urgent at full backlog", int'(urgent), 1);
        check(req == 1'b1, "R9 req held while backlog full", int'(req), 1);
        gmode = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 500 && (req || own); i++) @(negedge clk);
        delta = falls - base;
        check(delta >= MAX_PEND && delta <= MAX_PEND + 1, "R9 saturated backlog drained",
              delta, MAX_PEND);
        check(urgent == 1'b0, "R9 urgent cleared after drain", int'(urgent), 0);

        // Random grant latency with forced grant on urgency
        gmode = 2;
        repeat (2000) @(negedge clk);
        check(ready == 1'b1, "R10 ready still high", int'(ready), 1);
        gmode = 0;
        repeat (2 * REFI_CYC) @(negedge clk);
        check(urgent == 1'b0, "R9 no backlog with prompt grant", int'(urgent), 0);

        // RAS-only mode
        do_reset(1'b1);
        wait_ready(2000);
        check(int'(row_addr) == INIT_REFS % (1 << ROW_W), "R6 row counter after warm-up",
              int'(row_addr), INIT_REFS % (1 << ROW_W));
        chk_ival = 1'b1;
        repeat (15 * REFI_CYC) @(negedge clk);
        check(wrap_seen == 1'b1, "R6 row counter wrap", int'(wrap_seen), 1);
        check(ready == 1'b1, "R10 ready held in RAS-only run", int'(ready), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule